// File: doc/BRIEF.md
# All-Pairs Constant-Latency Maximum Finder

This block finds the largest of N unsigned keys in a fixed number of clock cycles, whatever the key values are. One comparator is built for each unordered index pair. Each comparator marks the smaller key of its pair as beaten. Every key except the largest loses at least one comparison, so exactly one key is still unmarked when the comparators finish. That key and its position are driven to the outputs.

A client places all N keys on a flat input bus and pulses `start`. The block latches the keys, registers the beaten flags, registers the single surviving position, and then presents the winner's value and binary index together with a one-cycle `valid` pulse. A `start` that arrives while a search is in flight is ignored. The result stays on the outputs until the next search replaces it.

Top module: `amx_top`

## Requirements
- R1: After reset, `valid`, `max_key` and `max_idx` are all 0.
- R2: `max_key` equals the largest key as an unsigned number. Key k is bits [k*W +: W] of `keys_in`.
- R3: `max_idx` is the binary position k of the key reported in `max_key`.
- R4: When several keys share the largest value, the highest index among them is reported. In each tied pair, the lower index is the one marked as beaten.
- R5: `valid` is high for exactly one cycle, which starts 3 clock edges after the edge that accepted `start`. It is low during the two cycles in between.
- R6: `start` is ignored while a search is in progress. Neither the result nor the timing of `valid` changes.
- R7: `max_key` and `max_idx` keep their last result after `valid` falls, until the next result is emitted.
- R8: After the compare-and-mark phase, exactly one beaten flag is clear.
- R9: N must be at least 3 and W at least 1. Other values are rejected when the design is elaborated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search; sampled only when idle |
| keys_in | input | N*W | Packed keys, key k in bits [k*W +: W] |
| valid | output | 1 | One-cycle result strobe |
| max_key | output | W | Largest key |
| max_idx | output | $clog2(N) | Index of the largest key |

## Verification
A broken comparator or a badly combined beaten flag leaves either zero or two positions unmarked. The encoder then produces a wrong or merged index and key. This shows up at the ports on the `valid` cycle of the very search whose data exercises that pair. The sweep covers every key combination of a four-key, three-bit configuration, so each pair is driven with less-than, equal and greater-than relations, including every tie pattern. A fault in the phase sequencing shows up as `valid` arriving one cycle early or late, or as a second pulse. A busy-start leak shows up as the result of the wrong keys.

// File: rtl/amx_pkg.sv
package amx_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_MARK = 2'd1,
      PH_PICK = 2'd2,
      PH_EMIT = 2'd3
   } amx_phase_e;

   // Linear slot of unordered pair (lo, hi), lo < hi, among n elements.
   function automatic int pair_slot(input int lo, input int hi, input int n);
      return lo * n - (lo * (lo + 1)) / 2 + (hi - lo - 1);
   endfunction

endpackage

// File: rtl/amx_pair_cmp.sv
module amx_pair_cmp #(
   parameter int W = 8
) (
   input  logic [W-1:0] key_lo,
   input  logic [W-1:0] key_hi,
   output logic         lo_beaten
);
   // Lower-index key loses on equality.
   assign lo_beaten = (key_lo <= key_hi);
endmodule

// File: rtl/amx_pair_grid.sv
module amx_pair_grid
   import amx_pkg::*;
#(
   parameter int N = 8,
   parameter int W = 8
) (
   input  logic [N*W-1:0] keys,
   output logic [N-1:0]   beaten
);
   localparam int NP = (N * (N - 1)) / 2;

   logic [NP-1:0] lo_lost;

   for (genvar gi = 0; gi < N; gi++) begin : g_row
      for (genvar gj = gi + 1; gj < N; gj++) begin : g_col
         localparam int SLOT = pair_slot(gi, gj, N);
         amx_pair_cmp #(.W(W)) u_cmp (
            .key_lo   (keys[gi*W +: W]),
            .key_hi   (keys[gj*W +: W]),
            .lo_beaten(lo_lost[SLOT])
         );
      end
   end

   // Many pairs may mark the same element; all write 1, so the result is an OR.
   always_comb begin
      beaten = '0;
      for (int i = 0; i < N; i++) begin
         for (int j = i + 1; j < N; j++) begin
            if (lo_lost[pair_slot(i, j, N)]) beaten[i] = 1'b1;
            else                             beaten[j] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/amx_onehot_enc.sv
module amx_onehot_enc #(
   parameter int N  = 8,
   parameter int W  = 8,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]   onehot,
   input  logic [N*W-1:0] keys,
   output logic [IW-1:0]  idx,
   output logic [W-1:0]   key
);
   always_comb begin
      idx = '0;
      key = '0;
      for (int k = 0; k < N; k++) begin
         if (onehot[k]) idx = idx | IW'(k);
         key = key | (keys[k*W +: W] & {W{onehot[k]}});
      end
   end
endmodule

// File: rtl/amx_top.sv
module amx_top
   import amx_pkg::*;
#(
   parameter int N  = 8,
   parameter int W  = 8,
   parameter int IW = $clog2(N)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [N*W-1:0] keys_in,
   output logic           valid,
   output logic [W-1:0]   max_key,
   output logic [IW-1:0]  max_idx
);
   // R9: elaboration-time parameter checks
   if (N < 3) begin : g_bad_n
      $error("amx_top: N must be at least 3");
   end
   if (W < 1) begin : g_bad_w
      $error("amx_top: W must be at least 1");
   end

   amx_phase_e     phase;
   logic [N*W-1:0] key_q;
   logic [N-1:0]   beaten_d, beaten_q;
   logic [N-1:0]   win_q;
   logic [IW-1:0]  enc_idx;
   logic [W-1:0]   enc_key;

   amx_pair_grid #(.N(N), .W(W)) u_grid (
      .keys  (key_q),
      .beaten(beaten_d)
   );

   amx_onehot_enc #(.N(N), .W(W), .IW(IW)) u_enc (
      .onehot(win_q),
      .keys  (key_q),
      .idx   (enc_idx),
      .key   (enc_key)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         key_q    <= '0;
         beaten_q <= '0;
         win_q    <= '0;
         valid    <= 1'b0;
         max_key  <= '0;
         max_idx  <= '0;
      end else begin
         valid <= 1'b0;
         unique case (phase)
            PH_IDLE: if (start) begin
               key_q <= keys_in;
               phase <= PH_MARK;
            end
            PH_MARK: begin
               beaten_q <= beaten_d;
               phase    <= PH_PICK;
            end
            PH_PICK: begin
               win_q <= ~beaten_q;
               phase <= PH_EMIT;
            end
            PH_EMIT: begin
               max_key <= enc_key;
               max_idx <= enc_idx;
               valid   <= 1'b1;
               phase   <= PH_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R8: exactly one element survives marking
   a_r8_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PICK) |-> ($countones(~beaten_q) == 1));

   // R5: emit phase is followed by the strobe, which lasts one cycle
   a_r5_emit_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_EMIT) |=> valid);
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   // R6: latched keys do not move while a search is running
   a_r6_keys_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE) |=> $stable(key_q));

   // R7: result holds between strobes
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid && $past(!valid)) |-> ($stable(max_key) && $stable(max_idx)));

   for (genvar k = 0; k < N; k++) begin : g_chk
      // R2: no latched key exceeds the reported maximum
      a_r2_not_below: assert property (@(posedge clk) disable iff (!rst_n)
         valid |-> (max_key >= key_q[k*W +: W]));
      // R4: a tied key never sits above the reported index
      a_r4_tie_high: assert property (@(posedge clk) disable iff (!rst_n)
         (valid && (key_q[k*W +: W] == max_key)) |-> (int'(max_idx) >= k));
   end
endmodule

// File: tb/amx_top_bench.sv
module amx_top_bench;
   localparam int N  = 4;
   localparam int W  = 3;
   localparam int IW = $clog2(N);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [N*W-1:0] keys_in = '0;
   logic           valid;
   logic [W-1:0]   max_key;
   logic [IW-1:0]  max_idx;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   amx_top #(.N(N), .W(W)) u_amx_top (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .keys_in(keys_in),
      .valid  (valid),
      .max_key(max_key),
      .max_idx(max_idx)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   // Expected per R2/R3/R4: largest value, highest index on ties.
   task automatic model(input logic [N*W-1:0] kv, output int mk, output int mi);
      mk = -1; mi = 0;
      for (int k = 0; k < N; k++) begin
         if (int'(kv[k*W +: W]) >= mk) begin
            mk = int'(kv[k*W +: W]);
            mi = k;
         end
      end
   endtask

   // One search; busy_kv is driven with start held during the busy cycles (R6).
   task automatic search(input logic [N*W-1:0] kv, input bit busy_poke,
                         input logic [N*W-1:0] busy_kv);
      int mk, mi;
      model(kv, mk, mi);
      keys_in = kv; start = 1'b1;
      @(negedge clk);                 // after accept edge
      if (busy_poke) keys_in = busy_kv; else start = 1'b0;
      @(negedge clk);                 // after mark edge
      chk(!valid, "R5 early valid", valid, 0);
      @(negedge clk);                 // after pick edge
      start = 1'b0;
      chk(!valid, "R5 early valid", valid, 0);
      @(negedge clk);                 // after emit edge
      chk(valid, "R5 valid at 3", valid, 1);
      chk(int'(max_key) == mk, busy_poke ? "R6 key" : "R2 key", max_key, mk);
      chk(int'(max_idx) == mi, busy_poke ? "R6 idx" : "R3/R4 idx", max_idx, mi);
   endtask

   initial begin
      #1_500_000;
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int mk, mi;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(valid == 1'b0, "R1 valid", valid, 0);
      chk(max_key == '0, "R1 key", max_key, 0);
      chk(max_idx == '0, "R1 idx", max_idx, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: all keys equal, top index wins
      search({3'd5, 3'd5, 3'd5, 3'd5}, 1'b0, '0);
      chk(max_idx == 2'd3, "R4 all tied", max_idx, 3);

      // R6: start held with other keys while busy
      search({3'd1, 3'd6, 3'd2, 3'd0}, 1'b1, {3'd7, 3'd7, 3'd7, 3'd7});
      @(negedge clk);
      // R5 single pulse, R7 hold
      chk(!valid, "R5 pulse width", valid, 0);
      chk(max_key == 3'd6, "R7 key hold", max_key, 6);
      chk(max_idx == 2'd2, "R7 idx hold", max_idx, 2);
      repeat (3) @(negedge clk);
      chk(max_key == 3'd6 && !valid, "R7 long hold", max_key, 6);

      // R2 R3 R4 R5 R8: exhaustive sweep of every key combination
      for (int v = 0; v < (1 << (N * W)); v++) begin
         search(v[N*W-1:0], 1'b0, '0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule